// File: doc/BRIEF.md
# Lockable Two-Way Set-Associative Read Cache

This block is a read-only cache with two ways per set. It is indexed and tagged directly with physical byte addresses, and it sits between a CPU-side request port and a memory-side burst port. A request that hits returns its 32-bit word one cycle after it is accepted. A request that misses starts one memory transaction. That transaction fetches the whole 16-byte line as four 32-bit beats. The first beat is the requested word, and the remaining beats follow in wrapping order. The CPU is answered as soon as that first beat arrives.

The victim way for a fill is chosen in this order. An unlocked invalid way is taken first. Otherwise the way that was not used most recently is taken. Any line can be pinned by issuing its request with `lock_i` high. A pinned line is never replaced. When both ways of a set are pinned, a miss in that set is still answered from memory, but nothing is allocated. A one-cycle `inval_i` pulse starts a sweep that visits one set per cycle. The sweep clears every valid bit, every lock bit and every recency bit. With the defaults (64 sets, 2 ways, 16-byte lines) the cache holds 2 Kbytes.

Address split: bits [1:0] select the byte and are ignored. Bits [3:2] select the word within the line. Bits [9:4] select the set. The bits above them form the tag.

Top module: `lockable_cache`

## Requirements
- R1: A request accepted on a hit raises `rsp_valid_o` for the cycle that follows the accepting edge. In that cycle `rsp_data_o` holds the stored word, and no memory request is issued.
- R2: A request accepted on a miss produces exactly one memory request. `mem_addr_o` carries the word address of the requested word (bits [1:0] zero) and stays stable while `mem_req_o` is held, until `mem_ack_i`. The four following beats carry the line words at offsets c, c+1, c+2, c+3 modulo 4, where c is the requested word offset.
- R3: On a miss, `rsp_valid_o` is high in the cycle after the first beat is sampled, and `rsp_data_o` equals that beat.
- R4: Once a fill completes, all four words of the line hit and return the data delivered for their offsets.
- R5: When both ways of a set are valid and unlocked, a fill replaces the way that was not the most recent one touched by a hit or a fill.
- R6: A fill uses an invalid way of its set before it evicts a valid line.
- R7: A request with `lock_i` high locks its line, either on a hit or on the fill it causes. A locked line is never chosen as a victim.
- R8: If both ways of the set are locked, a miss is still answered through a full burst, but it allocates nothing. A repeat of the same request misses again, and both locked lines keep hitting.
- R9: An accepted `inval_i` holds `req_ready_o` low for exactly SETS cycles. After that every line misses, and no lock survives.
- R10: After reset `req_ready_o` is high, `mem_req_o` and `rsp_valid_o` are low, and every access misses.
- R11: When `inval_i` and `req_valid_i` are both high in the idle state, `req_ready_o` is low and the request is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | CPU read request |
| req_addr_i | input | ADDR_W | Physical byte address |
| lock_i | input | 1 | Lock the addressed line |
| req_ready_o | output | 1 | Request accepted this cycle when high with req_valid_i |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | WORD_W | Read data |
| inval_i | input | 1 | Start invalidate-all sweep |
| mem_req_o | output | 1 | Line fetch request |
| mem_addr_o | output | ADDR_W | Word address of the critical word |
| mem_ack_i | input | 1 | Memory accepted the fetch |
| mem_rvalid_i | input | 1 | Burst beat valid |
| mem_rdata_i | input | WORD_W | Burst beat data |

## Verification
On every cycle the bound checker enforces several properties. A hit response arrives one cycle after acceptance, and a hit issues no memory fetch. The fetch address is word aligned and held steady until it is acknowledged. The victim selector never names a locked way. A set with both ways locked never allocates. No request is accepted while a fetch is outstanding. Other behaviours can only be shown by the bench's access sequences through the ports:
- the recency order across several accesses;
- the preference for invalid ways;
- the wrap order of the beats within the line;
- the length of the invalidate sweep and the release of locks after it.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int WAYS        = 2;
  localparam int LINE_WORDS  = 4;
  localparam int WOFF_W      = $clog2(LINE_WORDS);
  localparam int LINE_LSB    = WOFF_W + 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MREQ,
    ST_FILL,
    ST_INV
  } cache_st_e;
endpackage

// File: rtl/cache_tags.sv
module cache_tags
  import cache_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int TAG_W = 22,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic [WAYS-1:0]  hit_o,
  output logic [WAYS-1:0]  valid_o,
  output logic [WAYS-1:0]  lock_o,
  output logic             lru_o,
  input  logic             fill_we_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic             fill_way_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             fill_lock_i,
  input  logic             touch_we_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic             touch_way_i,
  input  logic             touch_lock_i,
  input  logic             clr_we_i,
  input  logic [IDX_W-1:0] clr_idx_i
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  lock_q  [SETS];
  logic [SETS-1:0]  lru_q;   // 1: way 1 is the replacement candidate
  logic [TAG_W-1:0] tag_q   [WAYS][SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        lock_q[s]  <= '0;
      end
      lru_q <= '0;
    end else begin
      if (clr_we_i) begin
        valid_q[clr_idx_i] <= '0;
        lock_q[clr_idx_i]  <= '0;
        lru_q[clr_idx_i]   <= 1'b0;
      end
      if (fill_we_i) begin
        valid_q[fill_idx_i][fill_way_i] <= 1'b1;
        lock_q[fill_idx_i][fill_way_i]  <= fill_lock_i;
        lru_q[fill_idx_i]               <= ~fill_way_i;
      end
      if (touch_we_i) begin
        lru_q[touch_idx_i] <= ~touch_way_i;
        if (touch_lock_i) lock_q[touch_idx_i][touch_way_i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_we_i) tag_q[fill_way_i][fill_idx_i] <= fill_tag_i;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_o[w] = valid_q[rd_idx_i][w] && (tag_q[w][rd_idx_i] == rd_tag_i);
  end

  assign valid_o = valid_q[rd_idx_i];
  assign lock_o  = lock_q[rd_idx_i];
  assign lru_o   = lru_q[rd_idx_i];
endmodule

// File: rtl/cache_victim.sv
module cache_victim
  import cache_pkg::*;
(
  input  logic [WAYS-1:0] valid_i,
  input  logic [WAYS-1:0] lock_i,
  input  logic            lru_i,
  output logic            way_o,
  output logic            none_o
);
  always_comb begin
    none_o = 1'b0;
    way_o  = lru_i;
    if (&lock_i)       none_o = 1'b1;
    else if (lock_i[0]) way_o = 1'b1;
    else if (lock_i[1]) way_o = 1'b0;
    else if (!valid_i[0]) way_o = 1'b0;
    else if (!valid_i[1]) way_o = 1'b1;
  end
endmodule

// File: rtl/cache_data.sv
module cache_data
  import cache_pkg::*;
#(
  parameter int SETS   = 64,
  parameter int WORD_W = 32,
  parameter int IDX_W  = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rd_way_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WOFF_W-1:0] rd_off_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              we_i,
  input  logic              wr_way_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WOFF_W-1:0] wr_off_i,
  input  logic [WORD_W-1:0] wr_data_i
);
  logic [WORD_W-1:0] mem_q [WAYS][SETS][LINE_WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_way_i][wr_idx_i][wr_off_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_way_i][rd_idx_i][rd_off_i];
endmodule

// File: rtl/lockable_cache.sv
module lockable_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int SETS   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              lock_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_data_o,
  input  logic              inval_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - LINE_LSB;
  localparam int LINE_W = TAG_W + IDX_W;

  cache_st_e         st_q;
  logic [LINE_W-1:0] line_q;
  logic [WOFF_W-1:0] crit_q, beat_q;
  logic              way_q, alloc_q, lk_q;
  logic [IDX_W-1:0]  inv_idx_q;
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_q;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WOFF_W-1:0] req_off;
  logic [WAYS-1:0]   hit_w, set_valid, set_lock;
  logic              set_lru, hit_any, hit_way;
  logic              vict_way, vict_none;
  logic              accept, last_beat;
  logic [WORD_W-1:0] rd_word;
  logic              unused_addr;

  assign req_tag = req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_idx = req_addr_i[LINE_LSB +: IDX_W];
  assign req_off = req_addr_i[2 +: WOFF_W];
  assign unused_addr = ^req_addr_i[1:0];

  assign hit_any     = |hit_w;
  assign hit_way     = hit_w[1];
  assign req_ready_o = (st_q == ST_IDLE) && !inval_i;
  assign accept      = req_valid_i && req_ready_o;
  assign last_beat   = (st_q == ST_FILL) && mem_rvalid_i && (beat_q == WOFF_W'(LINE_WORDS - 1));

  cache_tags #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (req_idx),
    .rd_tag_i    (req_tag),
    .hit_o       (hit_w),
    .valid_o     (set_valid),
    .lock_o      (set_lock),
    .lru_o       (set_lru),
    .fill_we_i   (last_beat && alloc_q),
    .fill_idx_i  (line_q[IDX_W-1:0]),
    .fill_way_i  (way_q),
    .fill_tag_i  (line_q[LINE_W-1 -: TAG_W]),
    .fill_lock_i (lk_q),
    .touch_we_i  (accept && hit_any),
    .touch_idx_i (req_idx),
    .touch_way_i (hit_way),
    .touch_lock_i(lock_i),
    .clr_we_i    (st_q == ST_INV),
    .clr_idx_i   (inv_idx_q)
  );

  cache_victim u_victim (
    .valid_i(set_valid),
    .lock_i (set_lock),
    .lru_i  (set_lru),
    .way_o  (vict_way),
    .none_o (vict_none)
  );

  cache_data #(.SETS(SETS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_data (
    .clk_i    (clk_i),
    .rd_way_i (hit_way),
    .rd_idx_i (req_idx),
    .rd_off_i (req_off),
    .rd_data_o(rd_word),
    .we_i     ((st_q == ST_FILL) && mem_rvalid_i && alloc_q),
    .wr_way_i (way_q),
    .wr_idx_i (line_q[IDX_W-1:0]),
    .wr_off_i (crit_q + beat_q),
    .wr_data_i(mem_rdata_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      line_q      <= '0;
      crit_q      <= '0;
      beat_q      <= '0;
      way_q       <= 1'b0;
      alloc_q     <= 1'b0;
      lk_q        <= 1'b0;
      inv_idx_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (inval_i) begin
            st_q      <= ST_INV;
            inv_idx_q <= '0;
          end else if (accept) begin
            if (hit_any) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= rd_word;
            end else begin
              st_q    <= ST_MREQ;
              line_q  <= {req_tag, req_idx};
              crit_q  <= req_off;
              way_q   <= vict_way;
              alloc_q <= !vict_none;
              lk_q    <= lock_i;
            end
          end
        end
        ST_MREQ: begin
          if (mem_ack_i) begin
            st_q   <= ST_FILL;
            beat_q <= '0;
          end
        end
        ST_FILL: begin
          if (mem_rvalid_i) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == '0) begin  // critical word goes straight out
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= mem_rdata_i;
            end
            if (last_beat) st_q <= ST_IDLE;
          end
        end
        ST_INV: begin
          inv_idx_q <= inv_idx_q + 1'b1;
          if (inv_idx_q == IDX_W'(SETS - 1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign mem_req_o   = (st_q == ST_MREQ);
  assign mem_addr_o  = {line_q, crit_q, 2'b00};
endmodule

// File: rtl/lockable_cache_chk.sv
module lockable_cache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              hit_i,
  input logic [1:0]        vict_lock_i,
  input logic              vict_way_i,
  input logic              vict_none_i
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  assert_hit_rsp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && hit_i |=> rsp_valid_o);

  assert_hit_no_fetch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && hit_i |=> !mem_req_o);

  assert_fetch_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  assert_fetch_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  assert_locked_safe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !hit_i && !vict_none_i |-> !vict_lock_i[vict_way_i]);

  assert_full_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !hit_i && (&vict_lock_i) |-> vict_none_i);

  assert_busy_fetch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
endmodule

bind lockable_cache lockable_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_ack_i  (mem_ack_i),
  .hit_i      (hit_any),
  .vict_lock_i(set_lock),
  .vict_way_i (vict_way),
  .vict_none_i(vict_none)
);

// File: tb/lockable_cache_tb.sv
`timescale 1ns/1ps
module lockable_cache_tb;
  localparam int SETS = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        lock_i = 1'b0;
  logic        req_ready_o, rsp_valid_o, mem_req_o;
  logic [31:0] rsp_data_o, mem_addr_o;
  logic        inval_i = 1'b0;
  logic        mem_ack_i = 1'b0;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #2.5 clk = ~clk;

  lockable_cache u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .lock_i(lock_i),
    .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
    .inval_i(inval_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  typedef struct {
    logic [31:0] data;
    bit          hit;
    int          acc;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_chk = 0, n_bad = 0;
  int          cyc = 0;
  int          mem_cnt = 0;
  int          beat0_cyc = 0;
  logic [31:0] exp_maddr = '0;
  bit          done = 1'b0;

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5a3c_0f96;
  endfunction

  function automatic logic [31:0] mk(input int tg, input int st, input int off);
    return (32'(tg) << 10) | (32'(st) << 4) | (32'(off) << 2);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: wrap-order burst from the requested word
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_o) begin
        mem_cnt++;
        check(mem_addr_o == exp_maddr, "R2 fetch address", mem_addr_o, exp_maddr);
        @(negedge clk);
        mem_ack_i = 1'b1;
        @(negedge clk);
        mem_ack_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
          logic [31:0] wa;
          wa = {mem_addr_o[31:4], 4'b0000} | {28'd0, 2'(mem_addr_o[3:2] + 2'(k)), 2'b00};
          mem_rvalid_i = 1'b1;
          mem_rdata_i  = memfn(wa);
          if (k == 0) beat0_cyc = cyc;
          @(negedge clk);
        end
        mem_rvalid_i = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && rsp_valid_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R11 unexpected response", rsp_data_o, 32'h0);
      end else begin
        exp_t e;
        int   want;
        e = sb_q.pop_front();
        check(rsp_data_o == e.data, e.tag, rsp_data_o, e.data);
        want = e.hit ? e.acc + 1 : beat0_cyc + 1;
        check(cyc == want, e.hit ? "R1 hit latency" : "R3 critical word timing",
              32'(cyc), 32'(want));
      end
    end
  end

  task automatic do_read(input logic [31:0] a, input bit lk, input bit exp_hit, input string tag);
    int   m0;
    exp_t e;
    m0 = mem_cnt;
    exp_maddr = {a[31:2], 2'b00};
    @(negedge clk);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    lock_i      = lk;
    while (!req_ready_o) @(negedge clk);
    e.data = memfn(a); e.hit = exp_hit; e.acc = cyc; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid_i = 1'b0;
    lock_i      = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    check((mem_cnt - m0) == (exp_hit ? 0 : 1), {tag, " hit/miss"}, 32'(mem_cnt - m0),
          exp_hit ? 32'd0 : 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready_o == 1'b1, "R10 ready after reset", 32'(req_ready_o), 32'd1);
    check(mem_req_o == 1'b0, "R10 no fetch in reset", 32'(mem_req_o), 32'd0);
    check(rsp_valid_o == 1'b0, "R10 no response in reset", 32'(rsp_valid_o), 32'd0);
    rst_ni = 1'b1;

    // R10/R2/R3: cold miss, critical word 2
    do_read(mk(1, 3, 2), 1'b0, 1'b0, "R10 cold miss");
    // R4/R1: all words of the line now hit
    do_read(mk(1, 3, 0), 1'b0, 1'b1, "R4 word 0");
    do_read(mk(1, 3, 1), 1'b0, 1'b1, "R4 word 1");
    do_read(mk(1, 3, 3), 1'b0, 1'b1, "R4 word 3");
    do_read(mk(1, 3, 2), 1'b0, 1'b1, "R1 word 2");

    // R6/R5 in set 5
    do_read(mk(1, 5, 0), 1'b0, 1'b0, "R6 fill A");
    do_read(mk(2, 5, 0), 1'b0, 1'b0, "R6 fill B");
    do_read(mk(1, 5, 0), 1'b0, 1'b1, "R6 A kept");
    do_read(mk(3, 5, 1), 1'b0, 1'b0, "R5 fill C");
    do_read(mk(1, 5, 3), 1'b0, 1'b1, "R5 recent A kept");
    do_read(mk(2, 5, 0), 1'b0, 1'b0, "R5 B evicted");

    // R7/R8 in set 9
    do_read(mk(1, 9, 0), 1'b1, 1'b0, "R7 fill A locked");
    do_read(mk(2, 9, 0), 1'b0, 1'b0, "R7 fill B");
    do_read(mk(2, 9, 1), 1'b0, 1'b1, "R7 hit B");
    do_read(mk(3, 9, 0), 1'b0, 1'b0, "R7 fill C");
    do_read(mk(1, 9, 2), 1'b0, 1'b1, "R7 locked A kept");
    do_read(mk(2, 9, 0), 1'b0, 1'b0, "R7 B evicted");
    do_read(mk(2, 9, 0), 1'b1, 1'b1, "R7 lock B on hit");
    do_read(mk(4, 9, 3), 1'b0, 1'b0, "R8 no-alloc miss");
    do_read(mk(4, 9, 3), 1'b0, 1'b0, "R8 repeat miss");
    do_read(mk(1, 9, 1), 1'b0, 1'b1, "R8 A still locked");
    do_read(mk(2, 9, 2), 1'b0, 1'b1, "R8 B still locked");

    // R11: invalidate wins over a simultaneous request
    @(negedge clk);
    inval_i = 1'b1;
    req_valid_i = 1'b1;
    req_addr_i = mk(1, 9, 0);
    #0.1;
    check(req_ready_o == 1'b0, "R11 ready under inval", 32'(req_ready_o), 32'd0);
    @(negedge clk);
    inval_i = 1'b0;
    req_valid_i = 1'b0;
    begin
      int lo;
      lo = 0;
      while (!req_ready_o && lo < 1000) begin
        lo++;
        @(negedge clk);
      end
      check(lo == SETS, "R9 sweep length", 32'(lo), 32'(SETS));
    end
    check(sb_q.size() == 0, "R11 request dropped", 32'(sb_q.size()), 32'd0);

    // R9: everything misses, locks gone
    do_read(mk(1, 9, 0), 1'b0, 1'b0, "R9 A misses");
    do_read(mk(1, 9, 0), 1'b0, 1'b1, "R9 A allocated");
    do_read(mk(1, 3, 2), 1'b0, 1'b0, "R9 set 3 misses");
    do_read(mk(3, 9, 0), 1'b0, 1'b0, "R9 fill C");
    do_read(mk(4, 9, 0), 1'b0, 1'b0, "R9 fill D unlocked");
    do_read(mk(4, 9, 0), 1'b0, 1'b1, "R9 D allocated");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule